// File: doc/BRIEF.md
# Power-Fail Write Guard and Backup Supply Switch

This block supervises a battery-backed static memory. It takes comparator flags for three supply levels: the switchover level near 3 V, the write-protect trip level and the full-function level. It also takes the memory's raw chip-enable and write-enable strobes. From these it drives gated strobes and a force-high-impedance signal for the memory, plus two switch controls. One switch connects the backup cell to the array and the other connects the external supply. The comparator flags arrive with no timing relation to the clock. Each one is synchronised and debounced before a five-state machine acts on it.

A battery fresh from shipment stays isolated until the supply first reaches the trip level. After that the backup path stays armed, and only a dedicated factory-reset input can undo it. When power returns, the strobes are held inactive through a counted recovery period. The count starts again whenever the full-function flag drops while it runs. Two comparator sets exist, one per tolerance grade, and a parameter picks which set is used.

Top module: `nvram_pwr_supervisor`

## Requirements
- R1: A comparator flag affects the block only after its synchronised value has differed from the filtered value for DEB_LEN consecutive clocks. A pulse shorter than that changes no output.
- R2: After factory reset the battery stays isolated (bat_conn_o = 0, vcc_conn_o = 1), even if the supply later falls below the switchover level. This lasts until the selected trip flag has been seen high.
- R3: Once armed, the backup path survives any number of rst_ni pulses and is cleared only by factory_rst_ni. After rst_ni with the switchover flag low, the battery is connected.
- R4: Whenever the state is not ACTIVE, hiz_o = 1 and ce_no = we_no = 1, whatever the raw strobes do. In particular this holds after a filtered trip flag falls in ACTIVE.
- R5: When armed and the filtered switchover flag is low, bat_conn_o = 1 and vcc_conn_o = 0.
- R6: When the filtered switchover flag is high, vcc_conn_o = 1 and bat_conn_o = 0.
- R7: bat_conn_o and vcc_conn_o are never 1 together.
- R8: Access (hiz_o = 0) starts only after REC_CYCLES consecutive clocks in recovery with the full flag high. The count restarts if the full flag drops first.
- R9: In ACTIVE, ce_no and we_no follow ce_ni and we_ni combinationally. The state stays ACTIVE while the supply sits between the trip level and the full level.
- R10: The flag inputs are indexed by grade: bit 0 is the wide-tolerance set and bit 1 is the narrow set. Only bit GRADE_NARROW is used, so the other bit has no effect.
- R11: Loss of the switchover flag takes priority over completion of the recovery count. If both fall in the same cycle, the block goes to battery and hiz_o never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset; keeps the arming state |
| factory_rst_ni | input | 1 | Active-low async reset that also re-seals the battery |
| above_swo_i | input | 1 | Supply above the ~3 V switchover level (async) |
| above_trip_i | input | 2 | Supply above the write-protect trip, per grade (async) |
| above_full_i | input | 2 | Supply above the full-function level, per grade (async) |
| ce_ni | input | 1 | Raw chip enable, active low |
| we_ni | input | 1 | Raw write enable, active low |
| ce_no | output | 1 | Gated chip enable to memory, active low |
| we_no | output | 1 | Gated write enable to memory, active low |
| hiz_o | output | 1 | Force memory data outputs to high impedance |
| bat_conn_o | output | 1 | Connect backup cell to the array |
| vcc_conn_o | output | 1 | Connect external supply to the array |

## Verification
The last recovery clock and the filtered loss of the switchover flag can land in the same cycle. The two competing outcomes are granting access and falling back to battery. The bench tracks the reference model's recovery count and drops the supply exactly when the debounce delay makes the filtered drop meet the final count. It then checks that hiz_o stayed high throughout and that the battery was connected. The same per-cycle comparison also covers the case where a full-flag drop during recovery restarts the count.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
  typedef enum logic [2:0] {
    ST_SEALED  = 3'd0,
    ST_ACTIVE  = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } sup_state_e;

  localparam int FLAG_SWO  = 0;
  localparam int FLAG_TRIP = 1;
  localparam int FLAG_FULL = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/nvps_flag_filter.sv
module nvps_flag_filter #(
  parameter int DEB_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic flag_o
);
  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_LEN - 1);

  logic sync1_q, sync2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      cnt_q   <= '0;
      flag_o  <= 1'b0;
    end else begin
      sync1_q <= flag_i;
      sync2_q <= sync1_q;
      if (sync2_q == flag_o) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        flag_o <= sync2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvps_rec_timer.sv
module nvps_rec_timer #(
  parameter int REC_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/nvps_seal.sv
module nvps_seal (
  input  logic clk_i,
  input  logic factory_rst_ni,
  input  logic break_i,
  output logic armed_o
);
  // only the factory reset may re-seal the cell
  always_ff @(posedge clk_i or negedge factory_rst_ni) begin
    if (!factory_rst_ni) armed_o <= 1'b0;
    else if (break_i)    armed_o <= 1'b1;
  end
endmodule

// File: rtl/nvram_pwr_supervisor.sv
module nvram_pwr_supervisor
  import nvps_pkg::*;
#(
  parameter bit GRADE_NARROW = 1'b0,
  parameter int DEB_LEN      = 4,
  parameter int REC_CYCLES   = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       factory_rst_ni,
  input  logic       above_swo_i,
  input  logic [1:0] above_trip_i,
  input  logic [1:0] above_full_i,
  input  logic       ce_ni,
  input  logic       we_ni,
  output logic       ce_no,
  output logic       we_no,
  output logic       hiz_o,
  output logic       bat_conn_o,
  output logic       vcc_conn_o
);
  localparam int GSEL = GRADE_NARROW ? 1 : 0;

  logic                 rst_all_n;
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] flt_q;
  logic                 armed_q;
  logic                 seal_break;
  logic                 rec_done;
  sup_state_e           state_q, state_d;

  assign rst_all_n = rst_ni & factory_rst_ni;

  assign raw_flags[FLAG_SWO]  = above_swo_i;
  assign raw_flags[FLAG_TRIP] = above_trip_i[GSEL];
  assign raw_flags[FLAG_FULL] = above_full_i[GSEL];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    nvps_flag_filter #(.DEB_LEN(DEB_LEN)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_all_n),
      .flag_i (raw_flags[g]),
      .flag_o (flt_q[g])
    );
  end

  assign seal_break = (state_q == ST_SEALED) && !armed_q && flt_q[FLAG_TRIP];

  nvps_seal u_seal (
    .clk_i          (clk_i),
    .factory_rst_ni (factory_rst_ni),
    .break_i        (seal_break),
    .armed_o        (armed_q)
  );

  nvps_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .run_i  (state_q == ST_RECOVER),
    .done_o (rec_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEALED: begin
        if (armed_q)                  state_d = flt_q[FLAG_SWO] ? ST_PROTECT : ST_BATTERY;
        else if (flt_q[FLAG_TRIP])    state_d = ST_PROTECT;
      end
      ST_ACTIVE: begin
        if (!flt_q[FLAG_SWO])         state_d = ST_BATTERY;
        else if (!flt_q[FLAG_TRIP])   state_d = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (!flt_q[FLAG_SWO])         state_d = ST_BATTERY;
        else if (flt_q[FLAG_FULL])    state_d = ST_RECOVER;
      end
      ST_BATTERY: begin
        if (flt_q[FLAG_SWO])          state_d = ST_PROTECT;
      end
      ST_RECOVER: begin
        // switchover loss outranks count completion
        if (!flt_q[FLAG_SWO])         state_d = ST_BATTERY;
        else if (!flt_q[FLAG_FULL])   state_d = ST_PROTECT;
        else if (rec_done)            state_d = ST_ACTIVE;
      end
      default:                        state_d = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) state_q <= ST_SEALED;
    else            state_q <= state_d;
  end

  assign hiz_o      = (state_q != ST_ACTIVE);
  assign ce_no      = (state_q == ST_ACTIVE) ? ce_ni : 1'b1;
  assign we_no      = (state_q == ST_ACTIVE) ? we_ni : 1'b1;
  assign bat_conn_o = (state_q == ST_BATTERY);
  assign vcc_conn_o = (state_q != ST_BATTERY);
endmodule

// File: rtl/nvps_checker.sv
module nvps_checker
  import nvps_pkg::*;
#(
  parameter int REC_CYCLES = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             factory_rst_ni,
  input sup_state_e       state_q,
  input logic             armed_q,
  input logic [NUM_FLAGS-1:0] flt_q,
  input logic             hiz_o,
  input logic             ce_no,
  input logic             we_no,
  input logic             bat_conn_o
);
  int rec_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rec_run_q <= 0;
    else if (state_q == ST_RECOVER)    rec_run_q <= rec_run_q + 1;
    else                               rec_run_q <= 0;
  end

  AST_HIZ_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    hiz_o |-> (ce_no && we_no)); // R4

  AST_ACCESS_FROM_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    $fell(hiz_o) |-> ($past(state_q) == ST_RECOVER)); // R8

  AST_RECOVERY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    $fell(hiz_o) |-> (rec_run_q == REC_CYCLES)); // R8

  AST_BATTERY_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    bat_conn_o |-> armed_q); // R2

  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!factory_rst_ni)
    armed_q |=> armed_q); // R3

  AST_TRIP_PROTECTS: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    (state_q == ST_ACTIVE && !flt_q[FLAG_TRIP]) |=> hiz_o); // R4

  AST_SWO_TO_BATTERY: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_rst_ni)
    (state_q == ST_PROTECT && armed_q && !flt_q[FLAG_SWO]) |=> bat_conn_o); // R5
endmodule

bind nvram_pwr_supervisor nvps_checker #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .factory_rst_ni (factory_rst_ni),
  .state_q        (state_q),
  .armed_q        (armed_q),
  .flt_q          (flt_q),
  .hiz_o          (hiz_o),
  .ce_no          (ce_no),
  .we_no          (we_no),
  .bat_conn_o     (bat_conn_o)
);

// File: tb/nvram_pwr_supervisor_tb.sv
module nvram_pwr_supervisor_tb;
  localparam int DEB = 3;
  localparam int REC = 20;
  localparam int S_SEAL = 0, S_ACT = 1, S_PROT = 2, S_BAT = 3, S_REC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fac_n, swo;
  logic [1:0] trip, full;
  logic ce_n, we_n;
  logic ce_o, we_o, hiz, bat, vcc;

  nvram_pwr_supervisor #(.GRADE_NARROW(1'b0), .DEB_LEN(DEB), .REC_CYCLES(REC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .factory_rst_ni(fac_n),
    .above_swo_i(swo), .above_trip_i(trip), .above_full_i(full),
    .ce_ni(ce_n), .we_ni(we_n),
    .ce_no(ce_o), .we_no(we_o), .hiz_o(hiz), .bat_conn_o(bat), .vcc_conn_o(vcc)
  );

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R2";

  // reference model
  int m_state, m_cnt;
  bit m_armed;
  bit s1 [3], s2 [3], f [3];
  int dc [3];

  always @(posedge clk or negedge rst_n or negedge fac_n) begin
    if (!fac_n) m_armed = 1'b0;
    if (!rst_n || !fac_n) begin
      m_state = S_SEAL; m_cnt = 0;
      for (int i = 0; i < 3; i++) begin s1[i] = 0; s2[i] = 0; f[i] = 0; dc[i] = 0; end
    end else begin
      int nst;
      bit raw [3];
      raw[0] = swo; raw[1] = trip[0]; raw[2] = full[0];
      nst = m_state;
      case (m_state)
        S_SEAL: if (m_armed) nst = f[0] ? S_PROT : S_BAT;
                else if (f[1]) begin nst = S_PROT; m_armed = 1'b1; end
        S_ACT:  if (!f[0]) nst = S_BAT; else if (!f[1]) nst = S_PROT;
        S_PROT: if (!f[0]) nst = S_BAT; else if (f[2]) nst = S_REC;
        S_BAT:  if (f[0]) nst = S_PROT;
        S_REC:  if (!f[0]) nst = S_BAT; else if (!f[2]) nst = S_PROT;
                else if (m_cnt == REC - 1) nst = S_ACT;
        default: nst = S_SEAL;
      endcase
      m_cnt = (m_state == S_REC) ? m_cnt + 1 : 0;
      m_state = nst;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == f[i]) dc[i] = 0;
        else if (dc[i] == DEB - 1) begin f[i] = s2[i]; dc[i] = 0; end
        else dc[i]++;
      end
      for (int i = 0; i < 3; i++) begin s2[i] = s1[i]; s1[i] = raw[i]; end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic e_act;
    e_act = (m_state == S_ACT);
    chk(phase, "hiz_o",      hiz, !e_act);
    chk(phase, "ce_no",      ce_o, e_act ? ce_n : 1'b1);
    chk(phase, "we_no",      we_o, e_act ? we_n : 1'b1);
    chk(phase, "bat_conn_o", bat, m_state == S_BAT);
    chk(phase, "vcc_conn_o", vcc, m_state != S_BAT);
    chk("R7", "exclusive switches", bat & vcc, 1'b0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // level: 0 below switchover, 1 below trip, 2 below full, 3 full.
  // R10: unused narrow-grade bits always carry the opposite value.
  task automatic set_lvl(int l);
    swo = (l >= 1);
    trip = {!(l >= 2), (l >= 2)};
    full = {!(l >= 3), (l >= 3)};
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    bit hiz_dropped;
    rst_n = 0; fac_n = 0; ce_n = 1; we_n = 1; set_lvl(0);
    cyc(3);
    chk("R2", "reset hiz", hiz, 1'b1);
    chk("R2", "reset bat", bat, 1'b0);
    rst_n = 1; fac_n = 1;
    phase = "R2";
    set_lvl(1); cyc(30);
    set_lvl(0); cyc(30);
    chk("R2", "sealed bat below switchover", bat, 1'b0);
    chk("R2", "sealed vcc below switchover", vcc, 1'b1);

    phase = "R1";
    set_lvl(3); cyc(DEB - 1);
    set_lvl(0); cyc(30);
    chk("R1", "glitch leaves seal", bat, 1'b0);

    phase = "R8";
    set_lvl(3);
    for (int k = 0; k < 40; k++) begin ce_n = k[0]; we_n = k[1]; cyc(1); end
    chk("R8", "access after recovery", hiz, 1'b0);

    phase = "R9";
    for (int k = 0; k < 8; k++) begin ce_n = k[1]; we_n = k[0]; cyc(1); end
    set_lvl(2); cyc(20);
    chk("R9", "hysteresis keeps access", hiz, 1'b0);

    phase = "R4";
    set_lvl(1);
    for (int k = 0; k < 20; k++) begin ce_n = k[0]; we_n = 0; cyc(1); end
    chk("R4", "strobes blocked", we_o, 1'b1);

    phase = "R5";
    set_lvl(0); cyc(15);
    chk("R5", "battery connected", bat, 1'b1);
    chk("R5", "supply isolated", vcc, 1'b0);
    phase = "R6";
    set_lvl(1); cyc(15);
    chk("R6", "supply reconnected", vcc, 1'b1);

    phase = "R8";
    set_lvl(3); cyc(15);
    set_lvl(2); cyc(12);
    set_lvl(3); cyc(15);
    chk("R8", "restart keeps hiz", hiz, 1'b1);
    cyc(30);
    chk("R8", "access after restart", hiz, 1'b0);

    phase = "R3";
    set_lvl(0); cyc(15);
    rst_n = 0; cyc(2); rst_n = 1; cyc(3);
    chk("R3", "armed across rst_ni", bat, 1'b1);

    phase = "R11";
    set_lvl(3);
    while (!(m_state == S_REC && m_cnt == REC - 6)) cyc(1);
    set_lvl(0);
    hiz_dropped = 0;
    for (int k = 0; k < 12; k++) begin cyc(1); if (hiz !== 1'b1) hiz_dropped = 1; end
    chk("R11", "no access on collision", hiz_dropped, 1'b0);
    chk("R11", "battery wins", bat, 1'b1);

    phase = "R2";
    fac_n = 0; cyc(2); fac_n = 1; cyc(20);
    chk("R2", "re-sealed after factory reset", bat, 1'b0);
    chk("R3", "factory reset clears arm", vcc, 1'b1);
    cyc(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule